// File: doc/BRIEF.md
# Interleaved multiphase PWM generator

This block drives up to four PWM phase outputs that feed one or two output rails. One free-running period counter acts as the shared oscillator. Every phase reads that counter through its own fixed offset, so the phases of a rail switch in turn across the period instead of all at once. A 3-bit mapping code decides which phases belong to rail A and which belong to rail B. A 3-bit frequency select chooses the period. The block captures both codes only while both rails are disabled.

Each rail supplies an 8-bit duty word. That word stands in for the loop compensation and the ramp comparison, and every phase of the rail uses it. The block turns the word into a high time in clock cycles and applies a minimum high pulse and a minimum low gap. A supervisor outside the block controls each rail with three inputs: an enable, a force-low that models the low-side switch held on, and a force-high-Z that overrides the force-low. Each phase output is either driven high, driven low, or released. Release means the output-enable bit is low.

Top module: `mpwm_gen`

## Requirements
- R1: The latched mapping code assigns phases as follows, with rail A listed first and rail B second:
  - 0 = {1} + {4}
  - 1 = {1,2} + {4}
  - 2 = {1,2,3} + {4}
  - 3 = {1,2} + {3,4}
  - 4 = {1}
  - 5 = {1,2}
  - 6 = {1,2,3}
  - 7 = {1,2,3,4}

  Phase n is bit n-1 of `pwm_o` and `pwm_oe`.
- R2: A phase that the latched code does not assign to a rail keeps `pwm_oe` low, even when both rail enables are high.
- R3: Every phase of a rail has high time H = floor(duty*P/256) cycles, where duty is the rail's 8-bit word and P is the period. The limits in R6 to R8 apply on top of this.
- R4: Let a rail have N phases. In rail A, the k-th phase (k from 0) rises k*P/N cycles after phase 1. In rail B, the k-th phase rises (2k+1)*P/(2N) cycles after phase 1. Both divisions are integer divisions.
- R5: With a 100 MHz clock, frequency select values 0 to 7 give 200, 300, 400, 500, 600, 800, 1000 and 1200 kHz. The period is P = floor(100000/kHz) cycles, which gives 500, 333, 250, 200, 166, 125, 100 and 83.
- R6: A nonzero duty word whose H falls below 5 cycles (50 ns) produces a 5-cycle high pulse.
- R7: A duty word below 255 whose H exceeds P-16 produces H = P-16, so every low gap is at least 16 cycles (160 ns).
- R8: Duty 0 gives a constant low. Duty 255 gives a constant high. Neither is subject to R6 or R7.
- R9: While a rail's enable is low, its phases are released in the same cycle. After the enable rises, each phase starts driving at the beginning of its own period, beginning with a full high pulse.
- R10: The mapping code and the frequency select are captured only on clock edges where both rail enables are low. Changes made while a rail is enabled have no effect.
- R11: When an enabled rail has force-low set, all of its phases drive low. When force-high-Z is set, the rail's phases are released, regardless of force-low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 100 MHz nominal |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_code | input | 3 | Phase-to-rail mapping code (R1) |
| fsel | input | 3 | Switching frequency select (R5) |
| ch_en | input | 2 | Rail run enables, bit 0 = rail A |
| duty_a | input | 8 | Duty word for rail A |
| duty_b | input | 8 | Duty word for rail B |
| force_low | input | 2 | Per-rail force all phases low |
| force_hiz | input | 2 | Per-rail release all phases, overrides force_low |
| pwm_o | output | 4 | Phase drive levels |
| pwm_oe | output | 4 | Phase drive enables, low = high impedance |

## Verification
The force and enable inputs act on the outputs combinationally. The bench therefore checks them at the first falling edge after it changes them. The mapping code and frequency select are captured at the next rising edge, and a duty word takes effect only at each phase's own period boundary. For each configuration the bench waits at least three full periods and then observes a window of exactly two periods. Within that window it counts high cycles and enable cycles and records rising edges. These counts and edge distances are independent of where the window falls within the period, so the checks do not depend on the exact cycle at which the window starts. The restart check after re-enabling a rail measures the length of the first pulse. This confirms that a phase starts with a full pulse and never with a partial one.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;

  localparam int NPH = 4;
  localparam int NCH = 2;

  typedef struct packed {
    logic       used;
    logic       chan;
    logic [1:0] idx;
    logic [2:0] cnt;
  } slot_t;

  function automatic int period_cycles(input logic [2:0] sel, input int clk_khz);
    int khz;
    case (sel)
      3'd0: khz = 200;
      3'd1: khz = 300;
      3'd2: khz = 400;
      3'd3: khz = 500;
      3'd4: khz = 600;
      3'd5: khz = 800;
      3'd6: khz = 1000;
      default: khz = 1200;
    endcase
    return clk_khz / khz;
  endfunction

  function automatic slot_t slot_of(input logic [2:0] code, input int ph);
    slot_t s;
    int n1;
    int n2;
    case (code)
      3'd0, 3'd4:        n1 = 1;
      3'd1, 3'd3, 3'd5:  n1 = 2;
      3'd2, 3'd6:        n1 = 3;
      default:           n1 = 4;
    endcase
    n2 = code[2] ? 0 : ((code == 3'd3) ? 2 : 1);
    s = '0;
    if (ph < n1) begin
      s.used = 1'b1;
      s.chan = 1'b0;
      s.idx  = 2'(ph);
      s.cnt  = 3'(n1);
    end else if (n2 != 0 && ph >= NPH - n2) begin
      s.used = 1'b1;
      s.chan = 1'b1;
      s.idx  = 2'(ph - (NPH - n2));
      s.cnt  = 3'(n2);
    end
    return s;
  endfunction

  function automatic int slot_offset(input slot_t s, input int per);
    if (!s.used || s.cnt == 3'd0) return 0;
    if (!s.chan) return (int'(s.idx) * per) / int'(s.cnt);
    return ((2 * int'(s.idx) + 1) * per) / (2 * int'(s.cnt));
  endfunction

endpackage

// File: rtl/mpwm_cfg.sv
module mpwm_cfg #(
  parameter int CLK_KHZ = 100000,
  parameter int PW      = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    code_in,
  input  logic [2:0]    fsel_in,
  input  logic [1:0]    ch_en,
  output logic [2:0]    code_q,
  output logic [PW-1:0] per_q
);
  import mpwm_pkg::*;

  logic          idle;
  logic [PW-1:0] per_d;

  always_comb begin
    idle  = ~|ch_en;
    per_d = PW'(period_cycles(fsel_in, CLK_KHZ));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      per_q  <= PW'(period_cycles(3'd0, CLK_KHZ));
    end else if (idle) begin
      code_q <= code_in;
      per_q  <= per_d;
    end
  end

  // R10: configuration frozen while any rail is enabled
  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_en) |=> ($stable(code_q) && $stable(per_q)));

endmodule

// File: rtl/mpwm_duty.sv
module mpwm_duty #(
  parameter int DW      = 8,
  parameter int PW      = 9,
  parameter int MIN_ON  = 5,
  parameter int MIN_OFF = 16
) (
  input  logic [DW-1:0] duty,
  input  logic [PW-1:0] per,
  output logic [PW-1:0] h_cyc
);
  localparam int XW = DW + PW;

  logic [XW-1:0] prod;
  logic [PW-1:0] raw;
  logic [PW-1:0] hi_lim;

  always_comb begin
    prod   = XW'(duty) * XW'(per);
    raw    = prod[XW-1:DW];
    hi_lim = per - PW'(MIN_OFF);
    if (duty == '0)                 h_cyc = '0;
    else if (duty == '1)            h_cyc = per;
    else if (raw < PW'(MIN_ON))     h_cyc = PW'(MIN_ON);
    else if (raw > hi_lim)          h_cyc = hi_lim;
    else                            h_cyc = raw;
  end

endmodule

// File: rtl/mpwm_phase.sv
module mpwm_phase #(
  parameter int PW      = 9,
  parameter int MIN_ON  = 5,
  parameter int MIN_OFF = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] cnt,
  input  logic [PW-1:0] per,
  input  logic [PW-1:0] off,
  input  logic          used,
  input  logic          en_ch,
  input  logic [PW-1:0] h_ch,
  input  logic          f_low,
  input  logic          f_hiz,
  output logic          pwm,
  output logic          oe
);
  logic [PW:0]   sum;
  logic [PW-1:0] loc;
  logic          wrap;
  logic          drive;
  logic [PW-1:0] h_q, h_d;
  logic          run_q, run_d;

  always_comb begin
    sum   = (cnt >= off) ? ({1'b0, cnt} - {1'b0, off})
                         : ({1'b0, cnt} + {1'b0, per} - {1'b0, off});
    loc   = sum[PW-1:0];
    wrap  = (loc == per - 1'b1);
    h_d   = wrap ? h_ch : h_q;
    run_d = (used && en_ch) ? (wrap | run_q) : 1'b0;
    drive = run_q && (loc < h_q);
    oe    = used && en_ch && !f_hiz && (f_low || run_q);
    pwm   = oe && !f_low && drive;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q   <= '0;
      run_q <= 1'b0;
    end else begin
      h_q   <= h_d;
      run_q <= run_d;
    end
  end

  // run-length counters feeding the pulse-width checks
  logic [PW-1:0] hi_run, lo_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0;
      lo_run <= '0;
    end else if (!run_q) begin
      hi_run <= '0;
      lo_run <= '0;
    end else if (drive) begin
      hi_run <= (hi_run == '1) ? hi_run : hi_run + 1'b1;
      lo_run <= '0;
    end else begin
      lo_run <= (lo_run == '1) ? lo_run : lo_run + 1'b1;
      hi_run <= '0;
    end
  end

  // R6: no high pulse shorter than the minimum on time
  p_min_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !drive && hi_run != '0) |-> (hi_run >= PW'(MIN_ON)));

  // R7: no low gap shorter than the minimum off time
  p_min_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && drive && lo_run != '0) |-> (lo_run >= PW'(MIN_OFF)));

endmodule

// File: rtl/mpwm_gen.sv
module mpwm_gen #(
  parameter int CLK_KHZ     = 100000,
  parameter int DW          = 8,
  parameter int MIN_ON_CYC  = 5,
  parameter int MIN_OFF_CYC = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    cfg_code,
  input  logic [2:0]    fsel,
  input  logic [1:0]    ch_en,
  input  logic [DW-1:0] duty_a,
  input  logic [DW-1:0] duty_b,
  input  logic [1:0]    force_low,
  input  logic [1:0]    force_hiz,
  output logic [3:0]    pwm_o,
  output logic [3:0]    pwm_oe
);
  import mpwm_pkg::*;

  localparam int PW = $clog2(CLK_KHZ / 200 + 1);

  logic [2:0]    code_q;
  logic [PW-1:0] per_q;
  logic [PW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] dval [NCH];
  logic [PW-1:0] h_ch [NCH];

  mpwm_cfg #(.CLK_KHZ(CLK_KHZ), .PW(PW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .code_in(cfg_code), .fsel_in(fsel),
    .ch_en(ch_en), .code_q(code_q), .per_q(per_q)
  );

  // shared oscillator
  always_comb cnt_d = (cnt_q >= per_q - 1'b1) ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_comb begin
    dval[0] = duty_a;
    dval[1] = duty_b;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_rail
    mpwm_duty #(.DW(DW), .PW(PW), .MIN_ON(MIN_ON_CYC), .MIN_OFF(MIN_OFF_CYC)) u_duty (
      .duty(dval[c]), .per(per_q), .h_cyc(h_ch[c])
    );
  end

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    slot_t         s;
    logic [PW-1:0] off;
    always_comb begin
      s   = slot_of(code_q, p);
      off = PW'(slot_offset(s, int'(per_q)));
    end
    mpwm_phase #(.PW(PW), .MIN_ON(MIN_ON_CYC), .MIN_OFF(MIN_OFF_CYC)) u_ph (
      .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .per(per_q), .off(off),
      .used(s.used), .en_ch(ch_en[s.chan]), .h_ch(h_ch[s.chan]),
      .f_low(force_low[s.chan]), .f_hiz(force_hiz[s.chan]),
      .pwm(pwm_o[p]), .oe(pwm_oe[p])
    );
  end

  // R2: phase 4 is released in the single-rail codes below 7
  p_unused_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q[2] && code_q != 3'd7) |-> !pwm_oe[3]);

  // R9: rail A disabled releases phase 1
  p_idle_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_en[0] |-> !pwm_oe[0]);

  // R11: force-high-Z on rail A releases phase 1
  p_force_hiz_r11: assert property (@(posedge clk) disable iff (!rst_n)
    force_hiz[0] |-> !pwm_oe[0]);

  // R11: force-low on an enabled rail A keeps phase 1 low
  p_force_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (force_low[0] && !force_hiz[0] && ch_en[0]) |-> (pwm_oe[0] && !pwm_o[0]));

endmodule

// File: tb/mpwm_gen_test.sv
module mpwm_gen_test;

  logic       clk;
  logic       rst_n;
  logic [2:0] cfg_code;
  logic [2:0] fsel;
  logic [1:0] ch_en;
  logic [7:0] duty_a;
  logic [7:0] duty_b;
  logic [1:0] force_low;
  logic [1:0] force_hiz;
  logic [3:0] pwm_o;
  logic [3:0] pwm_oe;

  int errors = 0;
  int checks = 0;
  int hcnt [4];
  int ocnt [4];
  int r1   [4];
  int r2   [4];

  mpwm_gen uut (
    .clk(clk), .rst_n(rst_n), .cfg_code(cfg_code), .fsel(fsel), .ch_en(ch_en),
    .duty_a(duty_a), .duty_b(duty_b), .force_low(force_low), .force_hiz(force_hiz),
    .pwm_o(pwm_o), .pwm_oe(pwm_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {code, fsel, duty_a, duty_b, period, high A, high B}
  localparam int VEC [8][7] = '{
    '{3, 3, 128,  64, 200, 100,  50},
    '{0, 6,   2, 254, 100,   5,  84},
    '{7, 5,  51,   0, 125,  24,   0},
    '{6, 7,   0,  77,  83,   0,   0},
    '{2, 0, 100, 255, 500, 195, 500},
    '{4, 1, 200,   9, 333, 260,   0},
    '{1, 4,   3, 128, 166,   5,  83},
    '{5, 2, 192,   0, 250, 187,   0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void masks(input int code, output logic [3:0] ma, output logic [3:0] mb);
    case (code)
      0: begin ma = 4'b0001; mb = 4'b1000; end
      1: begin ma = 4'b0011; mb = 4'b1000; end
      2: begin ma = 4'b0111; mb = 4'b1000; end
      3: begin ma = 4'b0011; mb = 4'b1100; end
      4: begin ma = 4'b0001; mb = 4'b0000; end
      5: begin ma = 4'b0011; mb = 4'b0000; end
      6: begin ma = 4'b0111; mb = 4'b0000; end
      default: begin ma = 4'b1111; mb = 4'b0000; end
    endcase
  endfunction

  task automatic measure(input int n);
    logic [3:0] prev;
    for (int p = 0; p < 4; p++) begin
      hcnt[p] = 0; ocnt[p] = 0; r1[p] = -1; r2[p] = -1;
    end
    @(negedge clk);
    prev = pwm_o;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      for (int p = 0; p < 4; p++) begin
        if (pwm_oe[p]) ocnt[p]++;
        if (pwm_o[p]) hcnt[p]++;
        if (pwm_o[p] && !prev[p]) begin
          if (r1[p] < 0) r1[p] = i;
          else if (r2[p] < 0) r2[p] = i;
        end
      end
      prev = pwm_o;
    end
  endtask

  task automatic start_vec(input int v);
    ch_en = 2'b00;
    repeat (3) @(negedge clk);
    cfg_code = 3'(VEC[v][0]);
    fsel     = 3'(VEC[v][1]);
    duty_a   = 8'(VEC[v][2]);
    duty_b   = 8'(VEC[v][3]);
    repeat (2) @(negedge clk);
    ch_en = 2'b11;
    repeat (3 * VEC[v][4] + 5) @(negedge clk);
  endtask

  task automatic run_vec(input int v);
    logic [3:0] ma, mb;
    int per, h, n, k, off, d;
    logic [3:0] m;
    start_vec(v);
    per = VEC[v][4];
    measure(2 * per);
    masks(VEC[v][0], ma, mb);
    for (int p = 0; p < 4; p++) begin
      if (ma[p] || mb[p]) begin
        m = ma[p] ? ma : mb;
        h = ma[p] ? VEC[v][5] : VEC[v][6];
        check(ocnt[p] == 2 * per, "R1 phase driven", ocnt[p], 2 * per);
        // R3 R6 R7 R8: high cycles over two periods
        check(hcnt[p] == 2 * h, "R3/R6/R7/R8 high time", hcnt[p], 2 * h);
        n = $countones(m);
        k = $countones(m & ((4'b0001 << p) - 4'b0001));
        off = ma[p] ? (k * per) / n : ((2 * k + 1) * per) / (2 * n);
        if (h > 0 && h < per && VEC[v][5] > 0 && VEC[v][5] < per && p != 0) begin
          d = (((r1[p] - r1[0]) % per) + per) % per;
          check(d == off, "R4 interleave offset", d, off);
        end
      end else begin
        check(ocnt[p] == 0, "R2 unused released", ocnt[p], 0);
      end
    end
    if (VEC[v][5] > 0 && VEC[v][5] < per)
      check(r2[0] - r1[0] == per, "R5 period", r2[0] - r1[0], per);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int len;
    int guard;
    rst_n = 1'b0; cfg_code = 3'd0; fsel = 3'd0; ch_en = 2'b00;
    duty_a = '0; duty_b = '0; force_low = '0; force_hiz = '0;
    repeat (3) @(negedge clk);
    check(pwm_oe == 4'b0000, "R9 reset released", int'(pwm_oe), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(pwm_oe == 4'b0000, "R9 idle released", int'(pwm_oe), 0);

    for (int v = 0; v < 8; v++) run_vec(v);

    // R10: code and period changes while running are ignored
    start_vec(0);
    cfg_code = 3'd7;
    fsel = 3'd7;
    repeat (400) @(negedge clk);
    measure(400);
    check(hcnt[2] == 100, "R10 mapping held", hcnt[2], 100);
    check(ocnt[3] == 400, "R10 rail B held", ocnt[3], 400);
    check(r2[0] - r1[0] == 200, "R10 period held", r2[0] - r1[0], 200);

    // R11: force-low then force-high-Z on rail A
    force_low = 2'b01;
    @(negedge clk);
    check(pwm_oe[1:0] == 2'b11, "R11 force low enables", int'(pwm_oe[1:0]), 3);
    check(pwm_o[1:0] == 2'b00, "R11 force low level", int'(pwm_o[1:0]), 0);
    measure(200);
    check(hcnt[0] == 0, "R11 no high under force low", hcnt[0], 0);
    check(hcnt[2] == 50, "R11 rail B unaffected", hcnt[2], 50);
    force_hiz = 2'b01;
    @(negedge clk);
    check(pwm_oe[1:0] == 2'b00, "R11 high-Z overrides", int'(pwm_oe[1:0]), 0);
    force_low = 2'b00;
    force_hiz = 2'b00;

    // R9: disable releases at once, restart begins with a full pulse
    ch_en = 2'b01;
    @(negedge clk);
    check(pwm_oe[3:2] == 2'b00, "R9 disable releases", int'(pwm_oe[3:2]), 0);
    repeat (10) @(negedge clk);
    ch_en = 2'b11;
    guard = 0;
    while (!pwm_oe[2] && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    check(pwm_o[2] == 1'b1, "R9 starts with rising edge", int'(pwm_o[2]), 1);
    len = 0;
    while (pwm_o[2] && len < 1000) begin
      len++;
      @(negedge clk);
    end
    check(len == 50, "R9 first pulse full width", len, 50);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule